// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is one 32-pin general-purpose I/O bank that sits behind a simple register bus made of an address, a write strobe, write data and combinational read data. Software uses it to drive pins as outputs, to read their synchronized state, and to set the pad controls: pull enable, pull direction and a 3-bit drive-strength code. The pad controls are held in registers and driven straight out to the pad ring.

Each pin also has its own event detector. Three per-pin control bits choose the sensing mode. Level sensing can be active-high or active-low. Edge sensing can catch a single rising edge, a single falling edge, or both edges. Detected events latch into a raw status register. A mask register gates raw status into a masked status view, and one interrupt line is the OR of that view. Software clears latched events by writing ones to a clear register, and it clears before servicing, so any event that arrives later latches again.

The design uses three leaf modules. The synchronizer is shared by all pins. One detector cell is instantiated per pin. The drive-strength planes sit in their own module and carry their own decode.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every writable register is zero. Therefore pin_out, pin_oe, pad_pull_en, pad_pull_up, pad_drive and irq_out are all zero, and every register reads back as zero.
- R2: The output-value register (offset 0x04) and the output-enable register (offset 0x08) take bus_wdata on the clock edge that samples the write. They appear on pin_out and pin_oe right after that edge and read back unchanged. Bit n belongs to pin n, and a 1 in output-enable makes pin n an output.
- R3: The input register (offset 0x00) returns pin_in after two synchronizing flops. A change on pin_in becomes readable after the second rising clock edge that follows it, and not after the first.
- R4: With the sense-type bit (offset 0x0C) at 0 and the dual bit at 0, a pin is edge-sensed. A polarity bit (offset 0x14) of 1 latches rising edges only, and 0 latches falling edges only. The raw status bit (offset 0x1C) sets on the third rising clock edge after the pin changes.
- R5: An edge-sensed pin whose dual bit (offset 0x10) is 1 latches status on both rising and falling transitions, whatever its polarity bit says.
- R6: With the sense-type bit at 1, a pin is level-sensed. Its raw status is set on every cycle in which the synchronized pin equals the polarity bit. A clear therefore leaves it set while that level persists, and takes effect once the level is gone.
- R7: Writing the clear register (offset 0x24) drops the raw status of each pin whose write bit is 1, and leaves pins written with 0 alone. The clear register reads as zero. If an event and a clear reach the same pin on the same edge, the event wins.
- R8: Masked status (offset 0x20) equals raw status AND the mask register (offset 0x18), where a mask bit of 1 enables the pin. irq_out is 1 exactly when any masked status bit is 1.
- R9: The pull-enable register (offset 0x38) drives pad_pull_en and the pull-direction register (offset 0x34) drives pad_pull_up. With enable at 0 the pin has no pull. With enable at 1, a direction of 1 means pull-up and 0 means pull-down. Both registers read back.
- R10: The drive-strength code (mA/2 - 1) is stored one bit per register: bit i of pin n's code is bit n of the register at offset 0x58 + 4*i, for i = 0..2. pad_drive[3n+2:3n] carries pin n's code, and each plane register reads back.
- R11: Writes to the input, raw-status and masked-status offsets change nothing. Offsets that map no register read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte offset inside the bank window |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data, bit n for pin n |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output values toward the pads |
| pin_oe | output | 32 | Per-pin output enable |
| pad_pull_en | output | 32 | Per-pin pull enable |
| pad_pull_up | output | 32 | Per-pin pull direction (1 = up) |
| pad_drive | output | 96 | Per-pin 3-bit drive-strength code, pin n at [3n+2:3n] |
| irq_out | output | 1 | OR of all masked status bits |

## Verification
Register writes take effect on the edge that samples the strobe, so the bench checks pad outputs and read-back on the following falling edge. A pin change driven on a falling edge becomes readable at the input offset after two rising edges. It reaches raw status, masked status and irq_out after three rising edges. The bench reads one falling edge early to prove the status bit is still clear, then reads again one cycle later to see it set. The case where an event meets a clear is timed so that the clear write is sampled on that same third edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Byte offsets of the bank registers; software decodes these.
    localparam int unsigned OFS_DIN    = 32'h00;
    localparam int unsigned OFS_DOUT   = 32'h04;
    localparam int unsigned OFS_OE     = 32'h08;
    localparam int unsigned OFS_STYPE  = 32'h0C;
    localparam int unsigned OFS_SDUAL  = 32'h10;
    localparam int unsigned OFS_SPOL   = 32'h14;
    localparam int unsigned OFS_MASK   = 32'h18;
    localparam int unsigned OFS_RAW    = 32'h1C;
    localparam int unsigned OFS_MST    = 32'h20;
    localparam int unsigned OFS_CLR    = 32'h24;
    localparam int unsigned OFS_PDIR   = 32'h34;
    localparam int unsigned OFS_PEN    = 32'h38;
    localparam int unsigned OFS_DRV0   = 32'h58;
    localparam int unsigned REG_STRIDE = 4;

    // Per-pin sensing selection.
    typedef struct packed {
        logic level;   // 1: level sensed, 0: edge sensed
        logic dual;    // edge mode only: both edges
        logic pol;     // 1: rising / high, 0: falling / low
    } sense_cfg_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] meta_q;

    // Two flops for metastability, a third keeps last cycle's value
    // so the detectors can compare current against previous.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
            q_prev <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
            q_prev <= q;
        end
    end

endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cur,
    input  logic       prev,
    input  sense_cfg_t cfg,
    input  logic       clr,
    output logic       status_q
);

    logic rise;
    logic fall;
    logic edge_hit;
    logic level_hit;
    logic hit;

    assign rise      = cur & ~prev;
    assign fall      = ~cur & prev;
    assign level_hit = (cur == cfg.pol);

    always_comb begin
        if (cfg.dual) begin
            edge_hit = rise | fall;
        end else if (cfg.pol) begin
            edge_hit = rise;
        end else begin
            edge_hit = fall;
        end
    end

    assign hit = cfg.level ? level_hit : edge_hit;

    // A new event overrides a clear landing on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else begin
            status_q <= hit | (status_q & ~clr);
        end
    end

    p_rise_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.level && !cfg.dual && cfg.pol && cur && !prev) |=> status_q);

    p_fall_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.level && !cfg.dual && !cfg.pol && !cur && prev) |=> status_q);

    p_dual_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.level && cfg.dual && (cur != prev)) |=> status_q);

    p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.level && (cur == cfg.pol)) |=> status_q);

    p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cfg.level && (cur == prev)) |=> !status_q);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !clr) |=> status_q);

endmodule

// File: rtl/gpio_bank_drive.sv
module gpio_bank_drive
    import gpio_bank_pkg::*;
#(
    parameter int          NPINS   = 32,
    parameter int          DS_BITS = 3,
    parameter int          ADDR_W  = 9,
    parameter int unsigned BASE    = OFS_DRV0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [NPINS-1:0]           bus_wdata,
    output logic                       rd_hit,
    output logic [NPINS-1:0]           rd_data,
    output logic [NPINS*DS_BITS-1:0]   pad_drive
);

    logic [NPINS-1:0]   plane_q [DS_BITS];
    logic [DS_BITS-1:0] sel;

    generate
        for (genvar p = 0; p < DS_BITS; p++) begin : g_plane
            localparam logic [ADDR_W-1:0] PLANE_ADDR =
                ADDR_W'(BASE + p * REG_STRIDE);

            assign sel[p] = (bus_addr == PLANE_ADDR);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    plane_q[p] <= '0;
                end else if (bus_we && sel[p]) begin
                    plane_q[p] <= bus_wdata;
                end
            end

            p_plane_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == PLANE_ADDR) |=> (plane_q[p] == $past(bus_wdata)));
        end

        // Transpose the bit planes into a per-pin code.
        for (genvar n = 0; n < NPINS; n++) begin : g_pin
            for (genvar b = 0; b < DS_BITS; b++) begin : g_bit
                assign pad_drive[n*DS_BITS + b] = plane_q[b][n];
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < DS_BITS; p++) begin
            if (sel[p]) begin
                rd_data = rd_data | plane_q[p];
            end
        end
    end

    assign rd_hit = |sel;

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int NPINS   = 32,
    parameter int ADDR_W  = 9,
    parameter int DS_BITS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [NPINS-1:0]         bus_wdata,
    output logic [NPINS-1:0]         bus_rdata,
    input  logic [NPINS-1:0]         pin_in,
    output logic [NPINS-1:0]         pin_out,
    output logic [NPINS-1:0]         pin_oe,
    output logic [NPINS-1:0]         pad_pull_en,
    output logic [NPINS-1:0]         pad_pull_up,
    output logic [NPINS*DS_BITS-1:0] pad_drive,
    output logic                     irq_out
);

    localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);
    localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(OFS_DOUT);
    localparam logic [ADDR_W-1:0] A_OE    = ADDR_W'(OFS_OE);
    localparam logic [ADDR_W-1:0] A_STYPE = ADDR_W'(OFS_STYPE);
    localparam logic [ADDR_W-1:0] A_SDUAL = ADDR_W'(OFS_SDUAL);
    localparam logic [ADDR_W-1:0] A_SPOL  = ADDR_W'(OFS_SPOL);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MST   = ADDR_W'(OFS_MST);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_PDIR  = ADDR_W'(OFS_PDIR);
    localparam logic [ADDR_W-1:0] A_PEN   = ADDR_W'(OFS_PEN);

    // Control registers
    logic [NPINS-1:0] dout_q;
    logic [NPINS-1:0] oe_q;
    logic [NPINS-1:0] stype_q;
    logic [NPINS-1:0] sdual_q;
    logic [NPINS-1:0] spol_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] pdir_q;
    logic [NPINS-1:0] pen_q;

    // Datapath
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] sync_prev;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] raw_st;
    logic [NPINS-1:0] masked_st;
    logic             drv_hit;
    logic [NPINS-1:0] drv_rd;
    sense_cfg_t       cfg_v [NPINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            oe_q    <= '0;
            stype_q <= '0;
            sdual_q <= '0;
            spol_q  <= '0;
            mask_q  <= '0;
            pdir_q  <= '0;
            pen_q   <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_DOUT:  dout_q  <= bus_wdata;
                A_OE:    oe_q    <= bus_wdata;
                A_STYPE: stype_q <= bus_wdata;
                A_SDUAL: sdual_q <= bus_wdata;
                A_SPOL:  spol_q  <= bus_wdata;
                A_MASK:  mask_q  <= bus_wdata;
                A_PDIR:  pdir_q  <= bus_wdata;
                A_PEN:   pen_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign clr_vec = (bus_we && (bus_addr == A_CLR)) ? bus_wdata : '0;

    gpio_bank_sync #(
        .W (NPINS)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (sync_q),
        .q_prev (sync_prev)
    );

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_cell
            assign cfg_v[i] = '{level: stype_q[i], dual: sdual_q[i], pol: spol_q[i]};

            gpio_bank_sense u_sense (
                .clk      (clk),
                .rst_n    (rst_n),
                .cur      (sync_q[i]),
                .prev     (sync_prev[i]),
                .cfg      (cfg_v[i]),
                .clr      (clr_vec[i]),
                .status_q (raw_st[i])
            );
        end
    endgenerate

    gpio_bank_drive #(
        .NPINS   (NPINS),
        .DS_BITS (DS_BITS),
        .ADDR_W  (ADDR_W),
        .BASE    (OFS_DRV0)
    ) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .rd_hit    (drv_hit),
        .rd_data   (drv_rd),
        .pad_drive (pad_drive)
    );

    assign masked_st = raw_st & mask_q;
    assign irq_out   = |masked_st;

    assign pin_out     = dout_q;
    assign pin_oe      = oe_q;
    assign pad_pull_en = pen_q;
    assign pad_pull_up = pdir_q;

    always_comb begin
        bus_rdata = '0;
        if (drv_hit) begin
            bus_rdata = drv_rd;
        end else begin
            case (bus_addr)
                A_DIN:   bus_rdata = sync_q;
                A_DOUT:  bus_rdata = dout_q;
                A_OE:    bus_rdata = oe_q;
                A_STYPE: bus_rdata = stype_q;
                A_SDUAL: bus_rdata = sdual_q;
                A_SPOL:  bus_rdata = spol_q;
                A_MASK:  bus_rdata = mask_q;
                A_RAW:   bus_rdata = raw_st;
                A_MST:   bus_rdata = masked_st;
                A_PDIR:  bus_rdata = pdir_q;
                A_PEN:   bus_rdata = pen_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_OE) |=> (pin_oe == $past(bus_wdata)));

    p_dout_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DOUT) |=> (pin_out == $past(bus_wdata)));

    p_irq_masked_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_out);

    p_pull_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PEN) |=> (pad_pull_en == $past(bus_wdata)));

    p_ro_dout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == A_RAW || bus_addr == A_MST || bus_addr == A_DIN)) |=> $stable(pin_out));

endmodule

// File: tb/sim_gpio_bank_irq.sv
`timescale 1ns/1ps
module sim_gpio_bank_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] pad_pull_en;
    logic [31:0] pad_pull_up;
    logic [95:0] pad_drive;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_bank_irq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up),
        .pad_drive   (pad_drive),
        .irq_out     (irq_out)
    );

    task automatic chk(input string req, input logic [95:0] got, input logic [95:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(9'h04, v); chk("R1 dout reads", v, 0);
        rd(9'h18, v); chk("R1 mask reads", v, 0);
        rd(9'h1C, v); chk("R1 raw reads", v, 0);
        rd(9'h5C, v); chk("R1 drive plane reads", v, 0);
        chk("R1 pads", {pin_out, pin_oe, pad_pull_en}, 0);
        chk("R1 drive pads", pad_drive, 0);
        chk("R1 irq", irq_out, 0);
    endtask

    task automatic t_outputs();
        logic [31:0] v;
        wr(9'h04, 32'hA5A5_3C3C);
        wr(9'h08, 32'h0F0F_00FF);
        @(negedge clk);
        chk("R2 pin_out", pin_out, 32'hA5A5_3C3C);
        chk("R2 pin_oe", pin_oe, 32'h0F0F_00FF);
        rd(9'h04, v); chk("R2 dout readback", v, 32'hA5A5_3C3C);
        rd(9'h08, v); chk("R2 oe readback", v, 32'h0F0F_00FF);
    endtask

    task automatic t_input();
        logic [31:0] v;
        drive_pins(32'h1234_8001);
        tick(1);
        rd(9'h00, v); chk("R3 din after one edge", v, 0);
        rd(9'h00, v); chk("R3 din after two edges", v, 32'h1234_8001);
        drive_pins(32'h0);
        tick(4);
        wr(9'h24, 32'hFFFF_FFFF);
        rd(9'h1C, v); chk("R7 clear all", v, 0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(9'h18, 32'hFFFF_FFFF);
        wr(9'h14, 32'h0000_0008);       // pin 3 rising, pin 5 falling
        drive_pins(32'h0000_0008);
        tick(2);
        rd(9'h1C, v); chk("R4 raw not yet set", v, 0);
        rd(9'h1C, v); chk("R4 rising latched", v, 32'h0000_0008);
        chk("R8 irq on rising", irq_out, 1);
        wr(9'h24, 32'h0000_0008);
        drive_pins(32'h0000_0020);      // pin 3 falls, pin 5 rises: no hit
        tick(4);
        rd(9'h1C, v); chk("R4 wrong edges ignored", v, 0);
        drive_pins(32'h0);              // pin 5 falls
        tick(3);
        rd(9'h1C, v); chk("R4 falling latched", v, 32'h0000_0020);
        wr(9'h24, 32'h0000_0020);
    endtask

    task automatic t_dual();
        logic [31:0] v;
        wr(9'h10, 32'h0000_0080);       // pin 7 dual, polarity 0
        drive_pins(32'h0000_0080);
        tick(3);
        rd(9'h1C, v); chk("R5 dual rise", v, 32'h0000_0080);
        wr(9'h24, 32'h0000_0080);
        drive_pins(32'h0);
        tick(3);
        rd(9'h1C, v); chk("R5 dual fall", v, 32'h0000_0080);
        wr(9'h24, 32'h0000_0080);
    endtask

    task automatic t_level();
        logic [31:0] v;
        drive_pins(32'h0000_0400);      // pin 10 high (level-low inactive)
        tick(4);
        wr(9'h24, 32'hFFFF_FFFF);
        wr(9'h14, 32'h0000_0208);       // pin 9 active-high
        wr(9'h0C, 32'h0000_0600);       // pins 9,10 level
        drive_pins(32'h0000_0600);      // pin 9 high
        tick(3);
        rd(9'h1C, v); chk("R6 level high latched", v, 32'h0000_0200);
        wr(9'h24, 32'h0000_0200);
        rd(9'h1C, v); chk("R6 clear ineffective while active", v, 32'h0000_0200);
        drive_pins(32'h0000_0400);
        tick(3);
        wr(9'h24, 32'h0000_0200);
        rd(9'h1C, v); chk("R6 clear after level gone", v, 0);
        drive_pins(32'h0);              // pin 10 low: active
        tick(3);
        rd(9'h1C, v); chk("R6 level low latched", v, 32'h0000_0400);
        drive_pins(32'h0000_0400);
        tick(3);
        wr(9'h24, 32'h0000_0400);
        rd(9'h1C, v); chk("R6 level low cleared", v, 0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(9'h10, 32'h0000_1080);       // pin 12 dual too
        drive_pins(32'h0000_1400);      // pin 12 rises
        tick(3);
        rd(9'h1C, v); chk("R7 pin12 set", v, 32'h0000_1000);
        wr(9'h24, 32'h0);
        rd(9'h1C, v); chk("R7 zero write keeps", v, 32'h0000_1000);
        rd(9'h24, v); chk("R7 clear reads zero", v, 0);
        drive_pins(32'h0000_0400);      // pin 12 falls
        tick(2);
        wr(9'h24, 32'h0000_1000);       // sampled on the latching edge
        rd(9'h1C, v); chk("R7 event beats clear", v, 32'h0000_1000);
        wr(9'h24, 32'h0000_1000);
        rd(9'h1C, v); chk("R7 later clear", v, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(9'h18, 32'h0);
        wr(9'h10, 32'h0000_5080);       // pin 14 dual
        drive_pins(32'h0000_4400);
        tick(3);
        rd(9'h20, v); chk("R8 masked off", v, 0);
        chk("R8 irq off", irq_out, 0);
        rd(9'h1C, v); chk("R8 raw still set", v, 32'h0000_4000);
        wr(9'h18, 32'h0000_4000);
        rd(9'h20, v); chk("R8 masked on", v, 32'h0000_4000);
        chk("R8 irq on", irq_out, 1);
        wr(9'h24, 32'h0000_4000);
        @(negedge clk);
        chk("R8 irq after clear", irq_out, 0);
    endtask

    task automatic t_pull();
        logic [31:0] v;
        wr(9'h38, 32'h00FF_0011);
        wr(9'h34, 32'h0F0F_0001);
        @(negedge clk);
        chk("R9 pull enable pads", pad_pull_en, 32'h00FF_0011);
        chk("R9 pull up pads", pad_pull_up, 32'h0F0F_0001);
        rd(9'h38, v); chk("R9 enable readback", v, 32'h00FF_0011);
        rd(9'h34, v); chk("R9 dir readback", v, 32'h0F0F_0001);
    endtask

    task automatic t_drive();
        logic [31:0] v;
        wr(9'h58, 32'h0000_0011);
        wr(9'h5C, 32'h0000_0001);
        wr(9'h60, 32'h8000_0011);
        @(negedge clk);
        chk("R10 pin0 code 7", pad_drive[2:0], 3'd7);
        chk("R10 pin4 code 5", pad_drive[14:12], 3'd5);
        chk("R10 pin31 code 4", pad_drive[95:93], 3'd4);
        chk("R10 pin1 code 0", pad_drive[5:3], 3'd0);
        rd(9'h5C, v); chk("R10 plane1 readback", v, 32'h0000_0001);
        rd(9'h60, v); chk("R10 plane2 readback", v, 32'h8000_0011);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(9'h1C, 32'hFFFF_FFFF);
        wr(9'h20, 32'hFFFF_FFFF);
        wr(9'h00, 32'hFFFF_FFFF);
        wr(9'h40, 32'hFFFF_FFFF);
        rd(9'h1C, v); chk("R11 raw unchanged", v, 0);
        rd(9'h00, v); chk("R11 din unchanged", v, 32'h0000_4400);
        rd(9'h04, v); chk("R11 dout unchanged", v, 32'hA5A5_3C3C);
        rd(9'h40, v); chk("R11 unmapped reads zero", v, 0);
        rd(9'h1FC, v); chk("R11 top of window zero", v, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_outputs();
        t_input();
        t_edge();
        t_dual();
        t_level();
        t_clear();
        t_mask();
        t_pull();
        t_drive();
        t_readonly();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule